// File: doc/BRIEF.md
# Eight-Channel Conversion Result Capture

This block sits behind the interface of a multichannel analog-to-digital converter. Each time the converter delivers a result, a one-cycle strobe arrives with a channel number and a 16-bit data word. The block keeps the most recent result of every channel in a register bank, and the host can read that bank at any time.

When queue mode is on, the block also writes results into an internal first-in first-out store. Each stored entry carries the sample together with the channel number and a timestamp. A decimation counter limits how many results enter the store. An interrupt request stays asserted while the store holds at least a programmable number of entries. If the store is full, the entry is lost and a sticky overflow flag is set.

The host side is modelled with plain inputs: a per-channel enable mask, the mode bit, the divide value, the threshold, a pop strobe and an overflow clear. The bus bridge, the serial converter protocol and the range coding are left to neighbouring blocks.

Top module: `smp_capture_top`

## Requirements
- R1: After reset the following hold: all channel registers read 0, the store count is 0, the empty flag is 1 and the overflow flag is 0.
- R2: A strobe for channel c with mask bit c set writes the data into channel c's register. The new value is visible on `last_words` from the next cycle. Channel k occupies bits [16k+15:16k]. Each 32-bit word therefore holds an even channel in its low half and the next odd channel in its high half.
- R3: A strobe whose channel has its mask bit at 0 is ignored. It changes no channel register, no store content, no store count and no decimation state.
- R4: With `cfg_fifo_mode` = 0, the channel registers keep updating and nothing is written into the store.
- R5: With `cfg_fifo_mode` = 1, channel registers update exactly as in R2. Selected results are also written into the store as the 32-bit entry {channel[31:29], timestamp[28:16], sample[15:0]}. The timestamp is a 13-bit counter that reads 0 in the first cycle after reset, advances every cycle and wraps. The entry carries the counter value of the strobe's cycle.
- R6: In queue mode the decimation counter advances only on accepted strobes. An accepted strobe is stored only when the counter is 0, and the counter then reloads from `cfg_div`. Otherwise the strobe is not stored and the counter decrements. The counter is held at 0 while queue mode is off. Hence, with divide value D, every (D+1)-th accepted result is stored, starting with the first one.
- R7: `fifo_rd_data` shows the oldest entry while the store is not empty. A `fifo_rd` pulse removes that entry. `fifo_count` tracks the occupancy, `fifo_empty` is 1 exactly when the count is 0, and a pop while empty is ignored.
- R8: `irq_almost_full` is 1 exactly while `fifo_count` >= `cfg_level`.
- R9: A store attempt while the count equals DEPTH is discarded and sets `ovf_sticky`. The flag stays set until a cycle with `ovf_clr` = 1 and no discarded store. If a discard and a clear occur in the same cycle, the flag is set.
- R10: A store and a pop in the same cycle leave the count unchanged when the store is neither empty nor full. When it is empty, the pop is ignored and the store succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Converter result strobe |
| res_chan | input | CHW | Channel number of the result |
| res_data | input | 16 | Conversion result |
| cfg_chan_en | input | NCH | Per-channel enable mask |
| cfg_fifo_mode | input | 1 | 1 = also write selected results into the store |
| cfg_div | input | 16 | Decimation divide value |
| cfg_level | input | CNTW | Occupancy threshold for the interrupt request |
| fifo_rd | input | 1 | Pop the oldest entry |
| ovf_clr | input | 1 | Clear the overflow flag |
| last_words | output | NCH*16 | Latest result of every channel, channel k at bits [16k+15:16k] |
| fifo_rd_data | output | 32 | Oldest store entry |
| fifo_count | output | CNTW | Store occupancy |
| fifo_empty | output | 1 | Store is empty |
| ovf_sticky | output | 1 | A store attempt was discarded |
| irq_almost_full | output | 1 | Occupancy is at or above the threshold |

## Verification
The bench fills the store past its depth. A design that lets the write pointer advance while full would corrupt the oldest entries, and one that loses a discard arriving in the same cycle as a clear would drop the overflow flag. Decimation with a non-zero divide value is checked for where the counter starts. A counter that began at the divide value instead of 0 would skip the first result. Disabled channels are exercised in both modes. If such strobes leaked into the counter, the later decimation phase would shift. Simultaneous push and pop are exercised on an empty store and on a partly filled one. Each of these is a place where a count would drift or a pop of nothing would underflow.

// File: rtl/smp_pkg.sv
package smp_pkg;
  localparam int SMP_W = 16;
  localparam int ENT_W = 32;
  localparam int DIV_W = 16;

  typedef struct packed {
    logic [SMP_W-1:0] tag;
    logic [SMP_W-1:0] smp;
  } smp_entry_t;

  function automatic smp_entry_t pack_entry(input logic [SMP_W-1:0] tag,
                                            input logic [SMP_W-1:0] smp);
    smp_entry_t e;
    e.tag = tag;
    e.smp = smp;
    return e;
  endfunction

  // next decimation count after an accepted result
  function automatic logic [DIV_W-1:0] decim_next(input logic [DIV_W-1:0] cnt,
                                                  input logic [DIV_W-1:0] div);
    return (cnt == '0) ? div : cnt - 1'b1;
  endfunction
endpackage

// File: rtl/smp_last_bank.sv
module smp_last_bank #(
  parameter int NCH = 8,
  localparam int CHW = $clog2(NCH),
  localparam int SW = smp_pkg::SMP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CHW-1:0]   wr_ch,
  input  logic [SW-1:0]    wr_data,
  output logic [NCH*SW-1:0] words
);
  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [SW-1:0] r_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               r_q <= '0;
      else if (wr_en && (wr_ch == CHW'(k)))     r_q <= wr_data;
    end
    assign words[k*SW +: SW] = r_q;
  end
endmodule

// File: rtl/smp_decim.sv
module smp_decim (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       hit,
  input  logic [smp_pkg::DIV_W-1:0]  div,
  output logic                       store
);
  logic [smp_pkg::DIV_W-1:0] cnt_q;

  assign store = run && hit && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else if (hit)  cnt_q <= smp_pkg::decim_next(cnt_q, div);
  end
endmodule

// File: rtl/smp_fifo.sv
module smp_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp_q <= wp_q + 1'b1;
      if (pop_ok)  rp_q <= rp_q + 1'b1;
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/smp_capture_top.sv
module smp_capture_top #(
  parameter int NCH = 8,
  parameter int DEPTH = 1024,
  localparam int CHW = $clog2(NCH),
  localparam int CNTW = $clog2(DEPTH + 1),
  localparam int SW = smp_pkg::SMP_W,
  localparam int TSW = SW - CHW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       res_valid,
  input  logic [CHW-1:0]             res_chan,
  input  logic [SW-1:0]              res_data,
  input  logic [NCH-1:0]             cfg_chan_en,
  input  logic                       cfg_fifo_mode,
  input  logic [smp_pkg::DIV_W-1:0]  cfg_div,
  input  logic [CNTW-1:0]            cfg_level,
  input  logic                       fifo_rd,
  input  logic                       ovf_clr,
  output logic [NCH*SW-1:0]          last_words,
  output logic [smp_pkg::ENT_W-1:0]  fifo_rd_data,
  output logic [CNTW-1:0]            fifo_count,
  output logic                       fifo_empty,
  output logic                       ovf_sticky,
  output logic                       irq_almost_full
);
  // named internal events (observed by the bound checker)
  logic             accept;
  logic             push_req;
  logic             push_ok;
  logic             pop_ok;
  logic             fifo_full;
  logic             drop_evt;
  logic [TSW-1:0]   ts_q;
  smp_pkg::smp_entry_t entry;

  assign accept   = res_valid && cfg_chan_en[res_chan];
  assign entry    = smp_pkg::pack_entry({res_chan, ts_q}, res_data);
  assign drop_evt = push_req && fifo_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else        ts_q <= ts_q + 1'b1;
  end

  smp_last_bank #(.NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_ch(res_chan),
    .wr_data(res_data), .words(last_words)
  );

  smp_decim u_decim (
    .clk(clk), .rst_n(rst_n), .run(cfg_fifo_mode), .hit(accept),
    .div(cfg_div), .store(push_req)
  );

  smp_fifo #(.DEPTH(DEPTH), .W(smp_pkg::ENT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(fifo_rd),
    .din(entry), .dout(fifo_rd_data), .count(fifo_count), .full(fifo_full),
    .empty(fifo_empty), .push_ok(push_ok), .pop_ok(pop_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ovf_sticky <= 1'b0;
    else if (drop_evt) ovf_sticky <= 1'b1;
    else if (ovf_clr)  ovf_sticky <= 1'b0;
  end

  assign irq_almost_full = (fifo_count >= cfg_level);
endmodule

// File: rtl/smp_capture_chk.sv
module smp_capture_chk #(
  parameter int NCH = 8,
  parameter int DEPTH = 1024,
  localparam int CHW = $clog2(NCH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            res_valid,
  input logic [CHW-1:0]  res_chan,
  input logic [NCH-1:0]  cfg_chan_en,
  input logic            cfg_fifo_mode,
  input logic            ovf_clr,
  input logic [CNTW-1:0] fifo_count,
  input logic            ovf_sticky,
  input logic            push_req,
  input logic            push_ok,
  input logic            pop_ok,
  input logic            drop_evt
);
  p_disabled_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !cfg_chan_en[res_chan]) |-> !push_req);

  p_cont_no_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_fifo_mode |-> !push_req);

  p_count_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && !pop_ok) |=> fifo_count == $past(fifo_count) + CNTW'(1));

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok) |=> fifo_count == $past(fifo_count) - CNTW'(1));

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNTW'(DEPTH));

  p_drop_sets_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_sticky);

  p_ovf_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sticky && !ovf_clr) |=> ovf_sticky);

  p_pair_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(fifo_count));
endmodule

bind smp_capture_top smp_capture_chk #(.NCH(NCH), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
  .cfg_chan_en(cfg_chan_en), .cfg_fifo_mode(cfg_fifo_mode), .ovf_clr(ovf_clr),
  .fifo_count(fifo_count), .ovf_sticky(ovf_sticky), .push_req(push_req),
  .push_ok(push_ok), .pop_ok(pop_ok), .drop_evt(drop_evt)
);

// File: tb/smp_capture_top_tb_top.sv
module smp_capture_top_tb_top;
  localparam int NCH = 8;
  localparam int DEPTH = 16;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [2:0] res_chan = '0;
  logic [15:0] res_data = '0;
  logic [NCH-1:0] cfg_chan_en = 8'hFF;
  logic cfg_fifo_mode = 1'b0;
  logic [15:0] cfg_div = '0;
  logic [CNTW-1:0] cfg_level = CNTW'(4);
  logic fifo_rd = 1'b0;
  logic ovf_clr = 1'b0;
  logic [NCH*16-1:0] last_words;
  logic [31:0] fifo_rd_data;
  logic [CNTW-1:0] fifo_count;
  logic fifo_empty, ovf_sticky, irq_almost_full;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // behavioural reference model
  logic [31:0] m_q[$];
  logic [15:0] m_last[NCH];
  logic [12:0] m_ts;
  int m_cnt;
  bit m_ovf;

  always #5 clk = ~clk;

  smp_capture_top #(.NCH(NCH), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .cfg_chan_en(cfg_chan_en), .cfg_fifo_mode(cfg_fifo_mode),
    .cfg_div(cfg_div), .cfg_level(cfg_level), .fifo_rd(fifo_rd), .ovf_clr(ovf_clr),
    .last_words(last_words), .fifo_rd_data(fifo_rd_data), .fifo_count(fifo_count),
    .fifo_empty(fifo_empty), .ovf_sticky(ovf_sticky), .irq_almost_full(irq_almost_full)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete();
      foreach (m_last[i]) m_last[i] = '0;
      m_ts = '0; m_cnt = 0; m_ovf = 1'b0;
    end else begin
      bit acc, st, was_full, was_empty;
      acc = res_valid && cfg_chan_en[res_chan];
      st = 1'b0;
      if (acc) m_last[res_chan] = res_data;
      if (!cfg_fifo_mode) m_cnt = 0;
      else if (acc) begin
        if (m_cnt == 0) begin st = 1'b1; m_cnt = int'(cfg_div); end
        else m_cnt = m_cnt - 1;
      end
      was_full = (m_q.size() == DEPTH);
      was_empty = (m_q.size() == 0);
      if (fifo_rd && !was_empty) void'(m_q.pop_front());
      if (st && !was_full) m_q.push_back({res_chan, m_ts, res_data});
      if (st && was_full) m_ovf = 1'b1;
      else if (ovf_clr) m_ovf = 1'b0;
      m_ts = m_ts + 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compared on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int i = 0; i < NCH; i++)
        chk(last_words[i*16 +: 16] === m_last[i], "R2", $sformatf("channel %0d register", i),
            32'(last_words[i*16 +: 16]), 32'(m_last[i]));
      chk(fifo_count === CNTW'(m_q.size()), "R7", "count", 32'(fifo_count), 32'(m_q.size()));
      chk(fifo_empty === (m_q.size() == 0), "R7", "empty flag", 32'(fifo_empty), 32'(m_q.size() == 0));
      if (m_q.size() > 0)
        chk(fifo_rd_data === m_q[0], "R5", "head entry", fifo_rd_data, m_q[0]);
      chk(irq_almost_full === (m_q.size() >= int'(cfg_level)), "R8", "interrupt request",
          32'(irq_almost_full), 32'(m_q.size() >= int'(cfg_level)));
      chk(ovf_sticky === m_ovf, "R9", "overflow flag", 32'(ovf_sticky), 32'(m_ovf));
    end
  end

  task automatic step(input bit v, input int ch, input logic [15:0] d, input bit rd, input bit clr);
    @(negedge clk); #1;
    res_valid = v; res_chan = 3'(ch); res_data = d; fifo_rd = rd; ovf_clr = clr;
  endtask

  task automatic drain();
    for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 16'h0, 1, 0);
    step(0, 0, 16'h0, 0, 0);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [CNTW-1:0] c0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(last_words === '0, "R1", "registers after reset", 32'(last_words[31:0]), 32'h0);
    chk(fifo_count === '0 && fifo_empty === 1'b1, "R1", "store after reset", 32'(fifo_count), 32'h0);
    chk(ovf_sticky === 1'b0, "R1", "overflow after reset", 32'(ovf_sticky), 32'h0);

    // R2 / R4: continuous mode on every channel
    for (int ch = 0; ch < NCH; ch++) step(1, ch, 16'h1000 + 16'(ch), 0, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(fifo_count === '0, "R4", "no store in continuous mode", 32'(fifo_count), 32'h0);
    chk(last_words[47:32] === 16'h1002 && last_words[63:48] === 16'h1003, "R2",
        "even/odd packing", last_words[63:32], 32'h1003_1002);

    // R3: disabled channels ignored
    cfg_chan_en = 8'h0F;
    step(1, 5, 16'hBEEF, 0, 0);
    step(1, 6, 16'hCAFE, 0, 0);
    cfg_fifo_mode = 1'b1;
    step(1, 7, 16'hD00D, 0, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(last_words[95:80] === 16'h1005, "R3", "disabled channel register", 32'(last_words[95:80]), 32'h1005);
    chk(fifo_count === '0, "R3", "disabled channel not stored", 32'(fifo_count), 32'h0);

    // R5 / R7 / R8: queue mode fill and read
    cfg_chan_en = 8'hFF;
    for (int i = 0; i < 6; i++) step(1, i, 16'h2000 + 16'(i), 0, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(fifo_count === CNTW'(6) && irq_almost_full === 1'b1, "R8", "level reached", 32'(fifo_count), 32'h6);
    chk(fifo_rd_data[31:29] === 3'd0 && fifo_rd_data[15:0] === 16'h2000, "R5", "entry fields",
        fifo_rd_data, 32'h2000);
    for (int i = 0; i < 3; i++) step(0, 0, 16'h0, 1, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(fifo_rd_data[15:0] === 16'h2003, "R7", "order after pops", 32'(fifo_rd_data[15:0]), 32'h2003);
    chk(irq_almost_full === 1'b0, "R8", "below level", 32'(irq_almost_full), 32'h0);

    // R10: push and pop together
    c0 = fifo_count;
    step(1, 1, 16'h3001, 1, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(fifo_count === c0, "R10", "count with push and pop", 32'(fifo_count), 32'(c0));
    drain();
    step(0, 0, 16'h0, 1, 0);
    step(1, 2, 16'h3002, 1, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(fifo_count === CNTW'(1), "R10", "push with pop on empty", 32'(fifo_count), 32'h1);
    drain();

    // R6: decimation by 3
    cfg_div = 16'd2;
    for (int i = 0; i < 9; i++) step(1, i % NCH, 16'h4000 + 16'(i), 0, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(fifo_count === CNTW'(3), "R6", "stored count with divide 2", 32'(fifo_count), 32'h3);
    chk(fifo_rd_data[15:0] === 16'h4000, "R6", "first result stored", 32'(fifo_rd_data[15:0]), 32'h4000);
    drain();

    // R9: overflow
    cfg_div = '0; cfg_level = CNTW'(DEPTH);
    for (int i = 0; i < DEPTH + 2; i++) step(1, i % NCH, 16'h5000 + 16'(i), 0, 0);
    step(0, 0, 16'h0, 0, 0);
    chk(ovf_sticky === 1'b1 && fifo_count === CNTW'(DEPTH), "R9", "overflow when full", 32'(ovf_sticky), 32'h1);
    chk(fifo_rd_data[15:0] === 16'h5000, "R9", "oldest kept after drop", 32'(fifo_rd_data[15:0]), 32'h5000);
    step(1, 3, 16'h5AAA, 0, 1);
    step(0, 0, 16'h0, 0, 0);
    chk(ovf_sticky === 1'b1, "R9", "drop wins over clear", 32'(ovf_sticky), 32'h1);
    step(0, 0, 16'h0, 0, 1);
    step(0, 0, 16'h0, 0, 0);
    chk(ovf_sticky === 1'b0, "R9", "cleared", 32'(ovf_sticky), 32'h0);
    drain();

    // mixed traffic against the model
    cfg_level = CNTW'(5);
    for (int i = 0; i < 600; i++) begin
      if (i % 50 == 0) begin
        cfg_div = 16'($urandom_range(0, 3));
        cfg_chan_en = 8'($urandom);
        cfg_fifo_mode = ($urandom_range(0, 4) != 0);
      end
      step($urandom_range(0, 2) != 0, int'($urandom_range(0, NCH - 1)), 16'($urandom),
           $urandom_range(0, 2) == 0, $urandom_range(0, 19) == 0);
    end
    step(0, 0, 16'h0, 0, 0);
    step(0, 0, 16'h0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule